// File: doc/BRIEF.md
# Out-of-Order Operation Scheduler with Tag Renaming

This block takes arithmetic operations one at a time and in program order, then lets them finish out of order. Each accepted operation goes into a free holding slot (a reservation station) of its class. Additions and subtractions use one pool of slots and multiplications and divisions use another. A source register whose value is still being computed is not read. The slot records the tag of the producing slot instead, so later writers of the same register cannot disturb it.

Every finished result travels on one shared result bus. Any slot waiting on that tag copies the value in the same cycle. The register file is written only by the producer that the register's pending-writer table still names. Each slot has a countdown timer that stands in for a fixed-latency functional unit.

An upstream sequencer drives the issue port and holds an operation until the block accepts it. A consumer observes the result bus. Architectural register contents can be read at any time through a separate read port.

Top module: `rs_scheduler`

## Requirements
- R1: After reset no slot is occupied, the result bus is idle, issue is ready for both classes, and architectural register i reads back the value i.
- R2: Operation code 0 is add, 1 is subtract, 2 is multiply and 3 is divide. Codes 0 and 1 use slots 0 to 2 and codes 2 and 3 use slots 3 and 4. The lowest-numbered free slot of the class is taken, and a slot's number is the tag it places on the result bus.
- R3: The issue port signals ready only while a slot of the offered operation's class is free. An operation is accepted in a cycle where valid and ready are both high. A slot that broadcasts in cycle c can accept a new operation from cycle c+1.
- R4: At acceptance a source is taken as a value when no pending writer is recorded for it. It is also taken as a value when its pending writer is on the result bus in that same cycle. Otherwise the producer's tag is kept, and the value is captured in the cycle that tag appears on the bus.
- R5: A slot starts executing in the first cycle in which both of its operands are already held. Its result reaches the bus no earlier than 2, 10 or 40 cycles after that start cycle, for add/subtract, multiply and divide respectively.
- R6: Results are taken modulo 2^DW: sum, difference, the low half of the product, and the unsigned quotient. Division by zero yields all ones.
- R7: Only one result is broadcast per cycle, and the oldest accepted operation among the finished ones wins. A finished operation that loses keeps its result and tries again in the next cycle.
- R8: A broadcast updates a register only when the register's pending-writer entry still names the broadcasting slot. An older producer that finishes after a newer writer of the same register leaves the register unchanged.
- R9: A value already captured by a waiting operation is not changed by a later operation that writes the same register.
- R10: The read port returns the current architectural value of the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An operation is offered |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 div) |
| iss_dst | input | log2(NREG) | Destination register |
| iss_src1 | input | log2(NREG) | First source register |
| iss_src2 | input | log2(NREG) | Second source register |
| iss_ready | output | 1 | A slot of the offered class is free |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | log2(NS) | Slot number of the broadcaster |
| cdb_data | output | DW | Broadcast result value |
| rf_raddr | input | log2(NREG) | Read port address |
| rf_rdata | output | DW | Architectural value at rf_raddr |

## Verification
The bench targets three corner cases. The first is a younger add that finishes in the same cycle as an older multiply. A wrong arbiter would let the add go first, or would drop the loser's result. The second is a register written twice with the older writer finishing last. A design without the pending-writer guard would leave the stale product in the register. The bench also issues an operation whose source producer broadcasts in the very cycle of issue. Without the bypass that operation would wait forever on a tag that never returns. Full-pool stalls, division by zero and a long random stream are compared against a behavioural model in every cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2
  } slot_st_e;
endpackage

// File: rtl/rs_age_arb.sv
module rs_age_arb #(
  parameter int NS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] alloc,
  input  logic [NS-1:0] req,
  output logic [NS-1:0] grant
);
  // older_q[j][i] set means slot j holds an operation accepted before slot i
  logic [NS-1:0] older_q [NS];
  logic [NS-1:0] older_d [NS];
  logic          age_en;

  assign age_en = |alloc;

  always_comb begin
    older_d = older_q;
    for (int k = 0; k < NS; k++) begin
      if (alloc[k]) begin
        older_d[k] = '0;
        for (int j = 0; j < NS; j++) begin
          if (j != k) older_d[j][k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NS; j++) older_q[j] <= '0;
    end else if (age_en) begin
      older_q <= older_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < NS; j++) begin
        if (j != i && req[j] && older_q[j][i]) blk = 1'b1;
      end
      grant[i] = req[i] & ~blk;
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|grant));
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rsq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int TW        = 3,
  parameter int RW        = 3,
  parameter bit IS_MULDIV = 1'b0,
  parameter int LAT_ADD   = 2,
  parameter int LAT_MUL   = 10,
  parameter int LAT_DIV   = 40,
  localparam int LMAX     = (LAT_ADD > LAT_MUL) ? ((LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV)
                                                : ((LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV),
  localparam int CW       = $clog2(LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [1:0]    a_op,
  input  logic [RW-1:0] a_dst,
  input  logic          a_rdy1,
  input  logic [TW-1:0] a_tag1,
  input  logic [DW-1:0] a_val1,
  input  logic          a_rdy2,
  input  logic [TW-1:0] a_tag2,
  input  logic [DW-1:0] a_val2,
  input  logic          bus_vld,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_val,
  input  logic          grant,
  output logic          is_free,
  output logic          req,
  output logic [DW-1:0] res,
  output logic [RW-1:0] dst
);
  slot_st_e      st_q, st_d;
  op_e           op_q, op_d;
  logic [RW-1:0] dst_q, dst_d;
  logic          r1_q, r1_d, r2_q, r2_d;
  logic [TW-1:0] t1_q, t1_d, t2_q, t2_d;
  logic [DW-1:0] v1_q, v1_d, v2_q, v2_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pl_en;

  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    dst_d = dst_q;
    r1_d  = r1_q;  t1_d = t1_q;  v1_d = v1_q;
    r2_d  = r2_q;  t2_d = t2_q;  v2_d = v2_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_FREE: begin
        if (alloc) begin
          st_d  = ST_WAIT;
          op_d  = op_e'(a_op);
          dst_d = a_dst;
          r1_d  = a_rdy1;  t1_d = a_tag1;  v1_d = a_val1;
          r2_d  = a_rdy2;  t2_d = a_tag2;  v2_d = a_val2;
        end
      end
      ST_WAIT: begin
        if (r1_q && r2_q) begin
          st_d = ST_EXEC;
          unique case (op_q)
            OP_ADD, OP_SUB: cnt_d = CW'(LAT_ADD - 1);
            OP_MUL:         cnt_d = CW'(LAT_MUL - 1);
            default:        cnt_d = CW'(LAT_DIV - 1);
          endcase
        end else begin
          if (!r1_q && bus_vld && bus_tag == t1_q) begin
            r1_d = 1'b1;
            v1_d = bus_val;
          end
          if (!r2_q && bus_vld && bus_tag == t2_q) begin
            r2_d = 1'b1;
            v2_d = bus_val;
          end
        end
      end
      ST_EXEC: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (grant)  st_d  = ST_FREE;
      end
      default: st_d = ST_FREE;
    endcase
  end

  assign pl_en = (st_q == ST_FREE && alloc) || (st_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FREE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_ADD;
      dst_q <= '0;
      r1_q  <= 1'b0;  t1_q <= '0;  v1_q <= '0;
      r2_q  <= 1'b0;  t2_q <= '0;  v2_q <= '0;
    end else if (pl_en) begin
      op_q  <= op_d;
      dst_q <= dst_d;
      r1_q  <= r1_d;  t1_q <= t1_d;  v1_q <= v1_d;
      r2_q  <= r2_d;  t2_q <= t2_d;  v2_q <= v2_d;
    end
  end

  generate
    if (IS_MULDIV) begin : g_muldiv
      logic [DW-1:0] prod, quot;
      assign prod = v1_q * v2_q;
      assign quot = (v2_q == '0) ? '1 : (v1_q / v2_q);
      assign res  = (op_q == OP_DIV) ? quot : prod;
    end else begin : g_addsub
      assign res = (op_q == OP_SUB) ? (v1_q - v2_q) : (v1_q + v2_q);
    end
  endgenerate

  assign is_free = (st_q == ST_FREE);
  assign req     = (st_q == ST_EXEC) && (cnt_q == '0);
  assign dst     = dst_q;

  // R5
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC) |=> ($stable(v1_q) && $stable(v2_q)));

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant) |=> (req && $stable(res)));

  // R3
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (st_q == ST_FREE));
endmodule

// File: rtl/rs_regfile.sv
module rs_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_vld,
  input  logic [TW-1:0] wb_tag,
  input  logic [RW-1:0] wb_dst,
  input  logic [DW-1:0] wb_val,
  input  logic          iss_we,
  input  logic [RW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic [RW-1:0] rd1_addr,
  output logic          rd1_busy,
  output logic [TW-1:0] rd1_tag,
  output logic [DW-1:0] rd1_val,
  input  logic [RW-1:0] rd2_addr,
  output logic          rd2_busy,
  output logic [TW-1:0] rd2_tag,
  output logic [DW-1:0] rd2_val,
  input  logic [RW-1:0] rd3_addr,
  output logic [DW-1:0] rd3_val
);
  logic [DW-1:0] rf_q [NREG];
  logic [DW-1:0] rf_d [NREG];
  logic [TW-1:0] stag_q [NREG];
  logic [TW-1:0] stag_d [NREG];
  logic [NREG-1:0] sv_q, sv_d;
  logic          upd_en;

  always_comb begin
    rf_d   = rf_q;
    stag_d = stag_q;
    sv_d   = sv_q;
    if (wb_vld && sv_q[wb_dst] && stag_q[wb_dst] == wb_tag) begin
      rf_d[wb_dst] = wb_val;
      sv_d[wb_dst] = 1'b0;
    end
    if (iss_we) begin
      sv_d[iss_dst]   = 1'b1;
      stag_d[iss_dst] = iss_tag;
    end
  end

  assign upd_en = wb_vld | iss_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rf_q[i]   <= DW'(i);
        stag_q[i] <= '0;
      end
      sv_q <= '0;
    end else if (upd_en) begin
      rf_q   <= rf_d;
      stag_q <= stag_d;
      sv_q   <= sv_d;
    end
  end

  assign rd1_busy = sv_q[rd1_addr];
  assign rd1_tag  = stag_q[rd1_addr];
  assign rd1_val  = rf_q[rd1_addr];
  assign rd2_busy = sv_q[rd2_addr];
  assign rd2_tag  = stag_q[rd2_addr];
  assign rd2_val  = rf_q[rd2_addr];
  assign rd3_val  = rf_q[rd3_addr];

  // R8
  busy_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_we |=> (sv_q[$past(iss_dst)] && stag_q[$past(iss_dst)] == $past(iss_tag)));
endmodule

// File: rtl/rs_scheduler.sv
module rs_scheduler #(
  parameter int DW      = 16,
  parameter int NREG    = 8,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40,
  localparam int NS     = N_ADD + N_MUL,
  localparam int TW     = $clog2(NS),
  localparam int RW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_src1,
  input  logic [RW-1:0] iss_src2,
  output logic          iss_ready,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_data,
  input  logic [RW-1:0] rf_raddr,
  output logic [DW-1:0] rf_rdata
);
  logic [NS-1:0] slot_free, slot_req, slot_gnt, cand, first, alloc;
  logic [DW-1:0] slot_res [NS];
  logic [RW-1:0] slot_dst [NS];
  logic [TW-1:0] new_tag;
  logic [RW-1:0] wb_dst;
  logic          fire;
  logic          s1_busy, s2_busy, s1_rdy, s2_rdy;
  logic [TW-1:0] s1_tag, s2_tag;
  logic [DW-1:0] s1_rf, s2_rf, s1_val, s2_val;

  // slot selection: lowest free slot of the class named by the opcode's upper bit
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      cand[i] = slot_free[i] && ((i >= N_ADD) == iss_op[1]);
    end
  end

  assign first     = cand & (~cand + 1'b1);
  assign iss_ready = |cand;
  assign fire      = iss_valid & iss_ready;
  assign alloc     = fire ? first : '0;

  always_comb begin
    new_tag = '0;
    for (int i = 0; i < NS; i++) begin
      if (first[i]) new_tag = TW'(i);
    end
  end

  // result bus multiplexer
  always_comb begin
    cdb_valid = |slot_gnt;
    cdb_tag   = '0;
    cdb_data  = '0;
    wb_dst    = '0;
    for (int i = 0; i < NS; i++) begin
      if (slot_gnt[i]) begin
        cdb_tag  = TW'(i);
        cdb_data = slot_res[i];
        wb_dst   = slot_dst[i];
      end
    end
  end

  rs_regfile #(.NREG(NREG), .DW(DW), .TW(TW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_vld   (cdb_valid),
    .wb_tag   (cdb_tag),
    .wb_dst   (wb_dst),
    .wb_val   (cdb_data),
    .iss_we   (fire),
    .iss_dst  (iss_dst),
    .iss_tag  (new_tag),
    .rd1_addr (iss_src1),
    .rd1_busy (s1_busy),
    .rd1_tag  (s1_tag),
    .rd1_val  (s1_rf),
    .rd2_addr (iss_src2),
    .rd2_busy (s2_busy),
    .rd2_tag  (s2_tag),
    .rd2_val  (s2_rf),
    .rd3_addr (rf_raddr),
    .rd3_val  (rf_rdata)
  );

  // source capture, including a producer broadcasting in the issue cycle
  always_comb begin
    s1_rdy = !s1_busy;
    s1_val = s1_rf;
    if (s1_busy && cdb_valid && s1_tag == cdb_tag) begin
      s1_rdy = 1'b1;
      s1_val = cdb_data;
    end
    s2_rdy = !s2_busy;
    s2_val = s2_rf;
    if (s2_busy && cdb_valid && s2_tag == cdb_tag) begin
      s2_rdy = 1'b1;
      s2_val = cdb_data;
    end
  end

  rs_age_arb #(.NS(NS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .alloc (alloc),
    .req   (slot_req),
    .grant (slot_gnt)
  );

  for (genvar g = 0; g < NS; g++) begin : g_slot
    rs_station #(
      .DW        (DW),
      .TW        (TW),
      .RW        (RW),
      .IS_MULDIV (g >= N_ADD),
      .LAT_ADD   (LAT_ADD),
      .LAT_MUL   (LAT_MUL),
      .LAT_DIV   (LAT_DIV)
    ) u_rs (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (alloc[g]),
      .a_op    (iss_op),
      .a_dst   (iss_dst),
      .a_rdy1  (s1_rdy),
      .a_tag1  (s1_tag),
      .a_val1  (s1_val),
      .a_rdy2  (s2_rdy),
      .a_tag2  (s2_tag),
      .a_val2  (s2_val),
      .bus_vld (cdb_valid),
      .bus_tag (cdb_tag),
      .bus_val (cdb_data),
      .grant   (slot_gnt[g]),
      .is_free (slot_free[g]),
      .req     (slot_req[g]),
      .res     (slot_res[g]),
      .dst     (slot_dst[g])
    );
  end
endmodule

// File: tb/sim_rs_scheduler.sv
module sim_rs_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 5;
  localparam int NADD  = 3;
  localparam int NR    = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid;
  logic [1:0] iss_op;
  logic [2:0] iss_dst, iss_src1, iss_src2, rf_raddr;
  logic       iss_ready, cdb_valid;
  logic [2:0] cdb_tag;
  logic [15:0] cdb_data, rf_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_scheduler u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  // behavioural reference model
  int m_busy[NSLOT], m_op[NSLOT], m_dst[NSLOT], m_v1[NSLOT], m_v2[NSLOT];
  int m_q1[NSLOT], m_q2[NSLOT], m_go[NSLOT], m_rem[NSLOT], m_seq[NSLOT];
  int m_rf[NR], m_stat[NR];
  int seq_ctr = 0, cyc = 0, errs = 0, checks = 0, force_rd = -1, last_rd = 0;
  bit finished = 0;

  function automatic int lat_of(int op);
    return (op < 2) ? 2 : ((op == 2) ? 10 : 40);
  endfunction

  function automatic int alu(int op, int a, int b);
    case (op)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: return (a * b) & 16'hFFFF;
      default: return (b == 0) ? 16'hFFFF : (a / b);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input int v, input int op, input int d, input int a, input int b,
                      output int fired);
    int g, gval, k, qa, qb, va, vb;
    @(negedge clk);
    iss_valid = v[0];
    iss_op    = 2'(op);
    iss_dst   = 3'(d);
    iss_src1  = 3'(a);
    iss_src2  = 3'(b);
    rf_raddr  = (force_rd >= 0) ? 3'(force_rd) : 3'(cyc % NR);
    #1;
    g = -1;
    for (int s = 0; s < NSLOT; s++)
      if (m_busy[s] && m_go[s] && m_rem[s] == 0 && (g < 0 || m_seq[s] < m_seq[g])) g = s;
    gval = (g >= 0) ? alu(m_op[g], m_v1[g], m_v2[g]) : 0;
    k = -1;
    for (int s = 0; s < NSLOT; s++)
      if (!m_busy[s] && ((s >= NADD) == (op >= 2)) && k < 0) k = s;
    chk("R3 issue ready", int'(iss_ready), int'(k >= 0));
    chk("R5 R7 bus valid", int'(cdb_valid), int'(g >= 0));
    if (g >= 0) begin
      chk("R2 R7 bus tag", int'(cdb_tag), g);
      chk("R4 R6 bus data", int'(cdb_data), gval);
    end
    last_rd = int'(rf_rdata);
    chk("R8 R10 register read", last_rd, m_rf[int'(rf_raddr)]);
    fired = (v != 0 && k >= 0) ? 1 : 0;
    // sources seen at acceptance (before this edge's updates)
    qa = -1; va = 0; qb = -1; vb = 0;
    if (fired != 0) begin
      if (m_stat[a] < 0) va = m_rf[a];
      else if (m_stat[a] == g) va = gval;
      else qa = m_stat[a];
      if (m_stat[b] < 0) vb = m_rf[b];
      else if (m_stat[b] == g) vb = gval;
      else qb = m_stat[b];
    end
    for (int s = 0; s < NSLOT; s++) begin
      if (m_busy[s]) begin
        if (s == g) m_busy[s] = 0;
        else if (!m_go[s]) begin
          if (m_q1[s] < 0 && m_q2[s] < 0) begin
            m_go[s] = 1; m_rem[s] = lat_of(m_op[s]) - 1;
          end else begin
            if (g >= 0 && m_q1[s] == g) begin m_q1[s] = -1; m_v1[s] = gval; end
            if (g >= 0 && m_q2[s] == g) begin m_q2[s] = -1; m_v2[s] = gval; end
          end
        end else if (m_rem[s] > 0) m_rem[s]--;
      end
    end
    if (g >= 0 && m_stat[m_dst[g]] == g) begin
      m_rf[m_dst[g]] = gval;
      m_stat[m_dst[g]] = -1;
    end
    if (fired != 0) begin
      m_busy[k] = 1; m_go[k] = 0; m_op[k] = op; m_dst[k] = d;
      m_q1[k] = qa; m_v1[k] = va; m_q2[k] = qb; m_v2[k] = vb;
      m_seq[k] = seq_ctr++;
      m_stat[d] = k;
    end
    cyc++;
  endtask

  task automatic issue(int op, int d, int a, int b);
    int f;
    do step(1, op, d, a, b, f); while (f == 0);
  endtask

  task automatic idle(int n);
    int f;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, f);
  endtask

  task automatic peek(string tag, int r, int exp);
    int f;
    force_rd = r;
    step(0, 0, 0, 0, 0, f);
    force_rd = -1;
    chk(tag, last_rd, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) m_busy[s] = 0;
    for (int r = 0; r < NR; r++) begin m_rf[r] = r; m_stat[r] = -1; end
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_dst = '0;
    iss_src1 = '0; iss_src2 = '0; rf_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, both classes ready, registers hold their index
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      rf_raddr = 3'(r); iss_op = 2'(r % 4);
      #1;
      chk("R1 register reset value", int'(rf_rdata), r);
      chk("R1 ready after reset", int'(iss_ready), 1);
      chk("R1 bus idle after reset", int'(cdb_valid), 0);
    end
    // R6: division by zero and subtract wrap
    issue(3, 1, 7, 0);
    issue(1, 6, 2, 3);
    idle(45);
    peek("R6 divide by zero", 1, 65535);
    peek("R6 subtract wraps", 6, 65535);
    // R8: older multiply to r4 finishes after newer add to r4
    issue(2, 4, 2, 3);
    issue(0, 4, 5, 5);
    idle(15);
    peek("R8 newest writer kept", 4, 10);
    // R9: reader of r2 keeps old value although r2 is rewritten later
    issue(2, 5, 2, 3);
    issue(0, 7, 5, 2);
    issue(0, 2, 3, 3);
    idle(20);
    peek("R9 captured value kept", 7, 8);
    peek("R9 later writer result", 2, 6);
    // R7: multiply and add complete in the same cycle; older multiply wins
    issue(2, 3, 4, 4);
    idle(7);
    issue(0, 0, 6, 6);
    idle(6);
    // R4: consumer issues in the cycle its producer broadcasts
    issue(2, 1, 2, 2);
    idle(10);
    issue(0, 6, 1, 1);
    idle(5);
    // R3: fill the add pool and the multiply pool to force stalls
    for (int i = 0; i < 5; i++) issue(i % 2, i + 1, i, i + 2 > 7 ? 0 : i + 2);
    for (int i = 0; i < 4; i++) issue(2 + (i % 2), 7 - i, i, i + 1);
    idle(60);
    // R5 R2: random stream compared every cycle
    for (int n = 0; n < 500; n++) begin
      int f, sel, op;
      sel = int'($urandom_range(0, 9));
      op  = (sel < 6) ? sel % 2 : ((sel < 9) ? 2 : 3);
      if ($urandom_range(0, 3) == 0) step(0, op, 0, 0, 0, f);
      else issue(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)));
    end
    idle(120);
    summary();
  end
endmodule